// File: doc/BRIEF.md
# Pre-decoded Shift-and-Compare Byte Pattern Matcher

This block scans a byte stream, taking at most one byte per clock, for a fixed set of byte strings. The set is chosen when the block is elaborated. Each incoming byte is compared once against every character value that some pattern needs. The result is a set of single-bit "this character just arrived" signals. Each of those signals runs into its own short shift register. A pattern is detected by AND-ing the right taps of those shared delay lines: a tap at delay d means "this character arrived d accepted bytes ago".

Patterns are grouped into partitions, and every partition builds its own independent set of character lines. A character value that no pattern in a partition uses costs that partition no logic at all. The block presents one registered detection bit per pattern. A downstream encoder would then choose among them. Bytes flow through with no back-pressure: the input is qualified by a valid strobe, and the delay lines move only on qualified bytes.

Top module: `predecoded_matcher`

## Requirements
- R1: Pattern p, character position i (i = 0 is the first character to arrive) is held in `PAT_BYTES[(p*MAX_LEN+i)*8 +: 8]`, its length in `PAT_LEN[p*8 +: 8]` and its partition in `PAT_PART[p*8 +: 8]`. `match_o[p]` is high in the clock cycle right after the rising edge that accepts the final character of an occurrence of pattern p.
- R2: A match bit stays high for exactly one cycle. It stays high longer only when the next accepted byte completes a further occurrence.
- R3: Cycles with `valid_i` low are ignored by the delay lines. An occurrence whose bytes are separated by idle cycles is still detected. In the cycle after an idle input cycle, every match bit is low.
- R4: Overlapping occurrences each give their own pulse. For example, the stream `ababab` detects `abab` after its 4th and 6th bytes.
- R5: An accepted byte that does not continue a pattern breaks that occurrence. No pulse is given for a pattern whose characters were not all seen at the correct relative delays.
- R6: A synchronous active-high `rst` clears every delay line and every match bit. Bytes presented while `rst` is high are dropped, and a prefix accepted before reset never completes an occurrence after it.
- R7: A one-character pattern fires in the cycle after each accepted copy of that character, so back-to-back copies give back-to-back pulses.
- R8: Patterns in different partitions are matched at the same time and independently on the same stream. The default set is: bit0 `abab` (partition 0), bit1 `ba` (partition 0), bit2 `cab` (partition 1), bit3 `x` (partition 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Qualifies `data_i` for this cycle |
| data_i | input | 8 | Stream byte |
| match_o | output | NUM_PAT | One registered detection pulse per pattern |

## Verification
Every detection is due exactly one rising edge after the edge that accepts the completing byte. An idle cycle or a reset forces all match bits low one edge later. The bench drives inputs and compares outputs only on the falling clock edge. At each falling edge it first compares `match_o` against the expectation it formed for the edge just passed, then applies the next inputs and forms the expectation for the following edge. The reference keeps a queue of the accepted bytes and tests the pattern strings against the queue's tail, so stalls, overlaps and resets are handled without reference to the delay-line structure.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_CHARS = 1 << BYTE_W;
  localparam int FIELD_W   = 8;   // width of a length or partition field

  typedef logic [BYTE_W-1:0] char_t;
endpackage

// File: rtl/pdm_char_line.sv
// One decoded character line: tap 0 is the live compare result, and tap d
// is the compare result from d accepted bytes ago.
module pdm_char_line #(
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic             hit_i,
  output logic [DEPTH:0]   taps_o
);

  assign taps_o[0] = hit_i;

  if (DEPTH > 0) begin : g_shift
    logic [DEPTH-1:0] line_q;

    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)          line_q <= '0;
        else if (valid_i) line_q <= hit_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)          line_q <= '0;
        else if (valid_i) line_q <= {line_q[DEPTH-2:0], hit_i};
      end
    end

    assign taps_o[DEPTH:1] = line_q;
  end

endmodule

// File: rtl/pdm_partition.sv
// One partition: it builds delay lines only for the characters its own
// patterns use, and ANDs the taps for each pattern placed in it.
module pdm_partition
  import pdm_pkg::*;
#(
  parameter int NUM_PAT = 4,
  parameter int MAX_LEN = 4,
  parameter int PART_ID = 0,
  parameter logic [NUM_PAT*MAX_LEN*BYTE_W-1:0] PAT_BYTES = '0,
  parameter logic [NUM_PAT*FIELD_W-1:0]        PAT_LEN   = '0,
  parameter logic [NUM_PAT*FIELD_W-1:0]        PAT_PART  = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid_i,
  input  char_t              data_i,
  output logic [NUM_PAT-1:0] hit_o
);

  function automatic int pat_len(int p);
    return int'(PAT_LEN[p*FIELD_W +: FIELD_W]);
  endfunction

  function automatic int pat_part(int p);
    return int'(PAT_PART[p*FIELD_W +: FIELD_W]);
  endfunction

  function automatic int pat_char(int p, int i);
    return int'(PAT_BYTES[(p*MAX_LEN+i)*BYTE_W +: BYTE_W]);
  endfunction

  // Longest delay at which character c is needed here; -1 when unused.
  function automatic int char_delay(int c);
    int d;
    d = -1;
    for (int p = 0; p < NUM_PAT; p++) begin
      if (pat_part(p) == PART_ID) begin
        for (int i = 0; i < MAX_LEN; i++) begin
          if (i < pat_len(p) && pat_char(p, i) == c && (pat_len(p) - 1 - i) > d)
            d = pat_len(p) - 1 - i;
        end
      end
    end
    return d;
  endfunction

  for (genvar c = 0; c < NUM_CHARS; c++) begin : g_ch
    localparam int DLY = char_delay(c);
    if (DLY >= 0) begin : g_used
      logic [DLY:0] taps;
      pdm_char_line #(.DEPTH(DLY)) u_line (
        .clk     (clk),
        .rst     (rst),
        .valid_i (valid_i),
        .hit_i   (data_i == char_t'(c)),
        .taps_o  (taps)
      );
    end
  end

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    localparam int L = pat_len(p);
    if (pat_part(p) == PART_ID && L > 0) begin : g_mine
      logic [L-1:0] pos_ok;
      for (genvar i = 0; i < L; i++) begin : g_pos
        localparam int CH = pat_char(p, i);
        localparam int DL = L - 1 - i;
        assign pos_ok[i] = g_ch[CH].g_used.taps[DL];
      end
      assign hit_o[p] = &pos_ok;
    end else begin : g_other
      assign hit_o[p] = 1'b0;
    end
  end

endmodule

// File: rtl/predecoded_matcher.sv
module predecoded_matcher
  import pdm_pkg::*;
#(
  parameter int NUM_PAT  = 4,
  parameter int MAX_LEN  = 4,
  parameter int NUM_PART = 2,
  // pattern p, char i at [(p*MAX_LEN+i)*8 +: 8]; i = 0 arrives first
  parameter logic [NUM_PAT*MAX_LEN*BYTE_W-1:0] PAT_BYTES =
    {8'h00, 8'h00, 8'h00, "x",      // p3: "x"
     8'h00, "b",   "a",   "c",      // p2: "cab"
     8'h00, 8'h00, "a",   "b",      // p1: "ba"
     "b",   "a",   "b",   "a"},     // p0: "abab"
  parameter logic [NUM_PAT*FIELD_W-1:0] PAT_LEN  = {8'd1, 8'd3, 8'd2, 8'd4},
  parameter logic [NUM_PAT*FIELD_W-1:0] PAT_PART = {8'd1, 8'd1, 8'd0, 8'd0}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid_i,
  input  logic [BYTE_W-1:0]  data_i,
  output logic [NUM_PAT-1:0] match_o
);

  logic [NUM_PART-1:0][NUM_PAT-1:0] part_hit;
  logic [NUM_PAT-1:0]               match_d;

  for (genvar k = 0; k < NUM_PART; k++) begin : g_part
    pdm_partition #(
      .NUM_PAT   (NUM_PAT),
      .MAX_LEN   (MAX_LEN),
      .PART_ID   (k),
      .PAT_BYTES (PAT_BYTES),
      .PAT_LEN   (PAT_LEN),
      .PAT_PART  (PAT_PART)
    ) u_part (
      .clk     (clk),
      .rst     (rst),
      .valid_i (valid_i),
      .data_i  (data_i),
      .hit_o   (part_hit[k])
    );
  end

  // Each pattern lives in exactly one partition; the others drive zero.
  always_comb begin
    match_d = '0;
    for (int k = 0; k < NUM_PART; k++) match_d = match_d | part_hit[k];
  end

  always_ff @(posedge clk) begin
    if (rst)          match_o <= '0;
    else if (valid_i) match_o <= match_d;
    else              match_o <= '0;
  end

endmodule

// File: rtl/pdm_checker.sv
module pdm_checker #(
  parameter int NUM_PAT = 4,
  parameter int MAX_LEN = 4,
  parameter logic [NUM_PAT*MAX_LEN*8-1:0] PAT_BYTES = '0,
  parameter logic [NUM_PAT*8-1:0]         PAT_LEN   = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               valid_i,
  input logic [7:0]         data_i,
  input logic [NUM_PAT-1:0] match_o
);

  // R6
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> match_o == '0);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> match_o == '0);

  // R2
  known_out_chk: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(match_o));

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_p
    localparam int LEN = int'(PAT_LEN[p*8 +: 8]);
    if (LEN > 0) begin : g_len
      localparam logic [7:0] LAST = PAT_BYTES[(p*MAX_LEN+LEN-1)*8 +: 8];
      // R1
      last_char_chk: assert property (@(posedge clk) disable iff (rst)
        match_o[p] |-> ($past(valid_i) && $past(data_i) == LAST));
    end
  end

endmodule

bind predecoded_matcher pdm_checker #(
  .NUM_PAT   (NUM_PAT),
  .MAX_LEN   (MAX_LEN),
  .PAT_BYTES (PAT_BYTES),
  .PAT_LEN   (PAT_LEN)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .valid_i (valid_i),
  .data_i  (data_i),
  .match_o (match_o)
);

// File: tb/predecoded_matcher_bench.sv
module predecoded_matcher_bench;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_i = 1'b0;
  logic [7:0]    data_i = 8'h00;
  logic [NP-1:0] match_o;

  always #4 clk = ~clk;   // 8 ns period

  predecoded_matcher u_predecoded_matcher (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_i),
    .data_i  (data_i),
    .match_o (match_o)
  );

  string         pats [NP] = '{"abab", "ba", "cab", "x"};
  byte unsigned  hist [$];
  logic [NP-1:0] exp_m = '0;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  function automatic logic [NP-1:0] model();
    logic [NP-1:0] m;
    m = '0;
    for (int p = 0; p < NP; p++) begin
      int len;
      bit ok;
      len = pats[p].len();
      ok  = (hist.size() >= len);
      if (ok)
        for (int i = 0; i < len; i++)
          if (hist[hist.size() - len + i] != pats[p][i]) ok = 0;
      m[p] = ok;
    end
    return m;
  endfunction

  // Compare the result of the edge just passed, then drive the next cycle.
  task automatic cyc(input bit r, input bit v, input byte unsigned d, input string tag);
    @(negedge clk);
    checks++;
    if (match_o !== exp_m) begin
      errors++;
      $display("FAIL %s match_o=%b expected=%b", tag, match_o, exp_m);
    end
    rst = r; valid_i = v; data_i = d;
    if (r) begin
      hist.delete();
      exp_m = '0;
    end else if (v) begin
      hist.push_back(d);
      if (hist.size() > 8) void'(hist.pop_front());
      exp_m = model();
    end else begin
      exp_m = '0;
    end
  endtask

  task automatic feed(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) cyc(0, 1, s[i], tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, tag);
  endtask

  initial begin
    byte unsigned alpha [5] = '{"a", "b", "c", "x", "z"};
    // R6: bytes offered during reset are dropped, outputs held at zero
    repeat (3) cyc(1, 1, "a", "R6 reset state");
    cyc(0, 0, 8'h00, "R6 reset state");
    // R1, R8: "ba" after byte 3, "abab" after byte 4
    feed("abab", "R1 basic");
    idle(1, "R2 single pulse");
    // R4: overlapping occurrences
    feed("ababab", "R4 overlap");
    idle(2, "R2 pulse ends");
    // R3: idle cycles inside an occurrence
    cyc(0, 1, "a", "R3 stall"); idle(1, "R3 stall");
    cyc(0, 1, "b", "R3 stall"); idle(2, "R3 stall");
    cyc(0, 1, "a", "R3 stall"); idle(1, "R3 stall");
    cyc(0, 1, "b", "R3 stall"); idle(1, "R3 stall");
    // R5: broken sequences
    feed("abzb", "R5 break");
    feed("cazb", "R5 break");
    idle(1, "R5 break");
    // R7: single-character pattern, back to back
    feed("xxax", "R7 single");
    idle(1, "R7 single");
    // R8: other partition, simultaneous partitions
    feed("cabab", "R8 partitions");
    feed("xcab", "R8 partitions");
    idle(1, "R8 partitions");
    // R6: prefix before reset must not complete after it
    feed("aba", "R6 prefix");
    cyc(1, 0, 8'h00, "R6 prefix");
    feed("b", "R6 prefix");
    idle(2, "R6 prefix");
    // R1: mixed stream with random stalls
    for (int n = 0; n < 3000; n++)
      cyc(0, ($urandom % 4) != 0, alpha[$urandom % 5], "R1 random");
    idle(2, "R1 random");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog cycles=200000 expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule